// File: doc/BRIEF.md
# Descriptor Table Register Unit

This unit carries out the system-register instruction group that the reg field of a ModR/M byte selects. It holds two table registers, one for the global descriptor table and one for the interrupt descriptor table, each made of a 16-bit limit and a 32-bit base. It also holds bits 3:0 of CR0, the machine status nibble, whose bit 0 is the protection-enable (PE) flag.

The decode stage issues one instruction with a single-cycle `start` pulse. The pulse carries the reg field, the operand form, the effective address, the segment selection, the current privilege level, the lock-prefix flag and a 16-bit register operand. The unit checks the instruction and then does one of two things. It may finish at once with a result or a fault. Otherwise it runs a byte-serial transfer over a request/acknowledge memory port and finishes when the last byte is acknowledged.

Every instruction ends with a one-cycle `done` pulse. That pulse carries a fault code, or an "unsupported" flag, or a status-word result. Address calculation, paging and TLB invalidation are handled elsewhere.

Top module: `dtr_unit`

## Requirements
- R1: After reset, both table limits read 0xFFFF, both bases read 0, `cr0_low` reads 0, and `done`, `fault_valid` and `mem_req` are low.
- R2: With a memory operand, `op_sel` 0 writes the global table register and `op_sel` 1 writes the interrupt table register as six bytes, with `mem_we` high, to `eff_addr`+0 through `eff_addr`+5. Bytes 0-1 hold the limit, low byte first, and bytes 2-5 hold the base, low byte first. `done` rises in the cycle after the sixth acknowledge.
- R3: With a memory operand, `op_sel` 2 loads the global table register and `op_sel` 3 loads the interrupt table register from six bytes in the layout of R2. The register changes only in the cycle that `done` rises, after the sixth acknowledge.
- R4: If `mem_fault` is high alongside `mem_ack` during a transfer, the transfer stops and `done` rises with `fault_code` 3. A table register or CR0 that was being loaded keeps its old value.
- R5: `op_sel` 0 through 3 in register form (`op_is_mem` low) end with `fault_code` 1 (invalid opcode) and issue no memory request.
- R6: `op_sel` 2, 3 and 6 with `cpl` not 0 end with `fault_code` 2 (general protection). This check comes before the operand-form check.
- R7: `op_sel` 4 returns the status word {12'b0, `cr0_low`} at any privilege level. In register form it appears on `msw_out` with `msw_valid` high. In memory form it is written as two bytes, low byte first.
- R8: `op_sel` 6 replaces `cr0_low` with bits 3:0 of its operand, taken from `rm_word` in register form or from two bytes read from memory in memory form.
- R9: If PE (`cr0_low` bit 0) is 1 and the `op_sel` 6 operand has bit 0 clear, the unit ends with `fault_code` 2 and leaves `cr0_low` unchanged. PE never goes from 1 to 0.
- R10: A lock prefix makes any instruction in the group end with `fault_code` 1, with no memory request and no state change.
- R11: `op_sel` 5 ends with `fault_code` 1. `op_sel` 7 ends with `unsupported` high, `fault_valid` low and no state change.
- R12: `mem_seg` is 3 (data segment) unless `seg_ovr_en` is set, in which case it is `seg_ovr`.
- R13: A `start` pulse during a transfer is ignored: it produces no extra `done` and changes no state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Issue pulse for one instruction |
| op_sel | input | 3 | ModR/M reg field selecting the operation |
| op_is_mem | input | 1 | Operand is in memory (1) or in a register (0) |
| eff_addr | input | 32 | Effective address of the memory operand |
| seg_ovr_en | input | 1 | Segment-override prefix present |
| seg_ovr | input | 3 | Override segment code |
| cpl | input | 2 | Current privilege level |
| lock_pfx | input | 1 | Lock prefix present |
| rm_word | input | 16 | Register operand for the status-word load |
| mem_req | output | 1 | Byte transfer request |
| mem_we | output | 1 | Request is a write |
| mem_seg | output | 3 | Segment code of the transfer |
| mem_addr | output | 32 | Byte address |
| mem_wdata | output | 8 | Write byte |
| mem_ack | input | 1 | Request accepted in this cycle |
| mem_rdata | input | 8 | Read byte, valid with `mem_ack` |
| mem_fault | input | 1 | Memory fault, valid with `mem_ack` |
| done | output | 1 | Instruction finished (one cycle) |
| fault_valid | output | 1 | Instruction ended in a fault |
| fault_code | output | 2 | 1 invalid opcode, 2 general protection, 3 memory fault |
| unsupported | output | 1 | Page-invalidate requested (not implemented) |
| msw_valid | output | 1 | `msw_out` holds a register-form status-word result |
| msw_out | output | 16 | Status word result |
| gdt_limit | output | 16 | Global table limit |
| gdt_base | output | 32 | Global table base |
| idt_limit | output | 16 | Interrupt table limit |
| idt_base | output | 32 | Interrupt table base |
| cr0_low | output | 4 | CR0 bits 3:0 |

## Verification
Some properties are checked on every cycle. PE never falls once set. A fault never comes with a change to CR0. A table register changes only at the end of its own load. An unsupported result never carries a fault. An invalid-opcode ending never overlaps a memory request. A stalled request holds its address. The transfer index stays inside the byte count. A new transfer never starts while one is running.

Other behaviour needs the bench's scenarios. These are the byte order of the images in memory, the priority of the privilege check over the form check, the segment chosen, a load left intact when a mid-transfer fault occurs, and a stray `start` that is ignored during a transfer.

// File: rtl/dtr_pkg.sv
package dtr_pkg;

    typedef enum logic [2:0] {
        OP_STORE_GDT = 3'd0,
        OP_STORE_IDT = 3'd1,
        OP_LOAD_GDT  = 3'd2,
        OP_LOAD_IDT  = 3'd3,
        OP_READ_MSW  = 3'd4,
        OP_RSVD      = 3'd5,
        OP_WRITE_MSW = 3'd6,
        OP_PG_INVAL  = 3'd7
    } op_e;

    typedef enum logic [1:0] {
        FC_NONE = 2'd0,
        FC_UD   = 2'd1,
        FC_GP   = 2'd2,
        FC_XFER = 2'd3
    } fault_e;

    localparam logic [2:0] SEG_DATA = 3'd3;

    // A status-word load may not drop the protection-enable bit.
    function automatic logic msw_blocked(input logic pe_now, input logic new_pe);
        return pe_now & ~new_pe;
    endfunction

    function automatic logic op_writes_mem(input op_e op);
        return (op == OP_STORE_GDT) || (op == OP_STORE_IDT) || (op == OP_READ_MSW);
    endfunction

endpackage

// File: rtl/dtr_decode.sv
module dtr_decode
    import dtr_pkg::*;
#(
    parameter int IMG_BYTES = 6,
    parameter int MSW_BYTES = 2,
    localparam int NB_W = $clog2(IMG_BYTES + 1)
) (
    input  op_e             op,
    input  logic            is_mem,
    input  logic [1:0]      cpl,
    input  logic            lock_pfx,
    input  logic            pe_now,
    input  logic            opnd_pe,
    output fault_e          fault,
    output logic            unsup,
    output logic            need_mem,
    output logic [NB_W-1:0] nbytes,
    output logic            msw_rd_reg,
    output logic            msw_wr_reg
);

    logic priv_ok;
    assign priv_ok = (cpl == 2'd0);

    always_comb begin
        fault      = FC_NONE;
        unsup      = 1'b0;
        need_mem   = 1'b0;
        nbytes     = NB_W'(IMG_BYTES);
        msw_rd_reg = 1'b0;
        msw_wr_reg = 1'b0;
        if (lock_pfx) begin
            fault = FC_UD;
        end else begin
            unique case (op)
                OP_STORE_GDT, OP_STORE_IDT: begin
                    if (!is_mem) fault = FC_UD;
                    else         need_mem = 1'b1;
                end
                OP_LOAD_GDT, OP_LOAD_IDT: begin
                    if (!priv_ok)     fault = FC_GP;
                    else if (!is_mem) fault = FC_UD;
                    else              need_mem = 1'b1;
                end
                OP_READ_MSW: begin
                    nbytes = NB_W'(MSW_BYTES);
                    if (is_mem) need_mem   = 1'b1;
                    else        msw_rd_reg = 1'b1;
                end
                OP_WRITE_MSW: begin
                    nbytes = NB_W'(MSW_BYTES);
                    if (!priv_ok)                         fault = FC_GP;
                    else if (is_mem)                      need_mem = 1'b1;
                    else if (msw_blocked(pe_now, opnd_pe)) fault = FC_GP;
                    else                                  msw_wr_reg = 1'b1;
                end
                OP_PG_INVAL: unsup = 1'b1;
                default:     fault = FC_UD;
            endcase
        end
    end

endmodule

// File: rtl/dtr_xfer.sv
module dtr_xfer #(
    parameter int MAX_BYTES = 6,
    localparam int NB_W = $clog2(MAX_BYTES + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            go,
    input  logic [NB_W-1:0] count,
    input  logic            ack,
    input  logic            fault,
    output logic            active,
    output logic [NB_W-1:0] idx,
    output logic            last_ok,
    output logic            failed
);

    typedef struct packed {
        logic            active;
        logic [NB_W-1:0] idx;
        logic [NB_W-1:0] cnt;
    } xs_t;

    xs_t s_d, s_q;

    assign active  = s_q.active;
    assign idx     = s_q.idx;
    assign last_ok = s_q.active && ack && !fault && (s_q.idx == s_q.cnt - NB_W'(1));
    assign failed  = s_q.active && ack && fault;

    always_comb begin
        s_d = s_q;
        if (!s_q.active) begin
            if (go) begin
                s_d.active = 1'b1;
                s_d.idx    = '0;
                s_d.cnt    = count;
            end
        end else if (ack) begin
            if (fault || (s_q.idx == s_q.cnt - NB_W'(1))) s_d.active = 1'b0;
            else                                          s_d.idx = s_q.idx + NB_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    p_idx_in_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.active |-> (s_q.idx < s_q.cnt));

    p_no_restart_r13: assert property (@(posedge clk) disable iff (!rst_n)
        go |-> !s_q.active);

endmodule

// File: rtl/dtr_unit.sv
module dtr_unit
    import dtr_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int LIMIT_W = 16,
    parameter int BASE_W  = 32,
    localparam int IMG_W     = LIMIT_W + BASE_W,
    localparam int IMG_BYTES = IMG_W / 8,
    localparam int MSW_BYTES = 2,
    localparam int NB_W      = $clog2(IMG_BYTES + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [2:0]         op_sel,
    input  logic               op_is_mem,
    input  logic [ADDR_W-1:0]  eff_addr,
    input  logic               seg_ovr_en,
    input  logic [2:0]         seg_ovr,
    input  logic [1:0]         cpl,
    input  logic               lock_pfx,
    input  logic [15:0]        rm_word,
    output logic               mem_req,
    output logic               mem_we,
    output logic [2:0]         mem_seg,
    output logic [ADDR_W-1:0]  mem_addr,
    output logic [7:0]         mem_wdata,
    input  logic               mem_ack,
    input  logic [7:0]         mem_rdata,
    input  logic               mem_fault,
    output logic               done,
    output logic               fault_valid,
    output logic [1:0]         fault_code,
    output logic               unsupported,
    output logic               msw_valid,
    output logic [15:0]        msw_out,
    output logic [LIMIT_W-1:0] gdt_limit,
    output logic [BASE_W-1:0]  gdt_base,
    output logic [LIMIT_W-1:0] idt_limit,
    output logic [BASE_W-1:0]  idt_base,
    output logic [3:0]         cr0_low
);

    typedef struct packed {
        op_e                op;
        logic [2:0]         seg;
        logic [ADDR_W-1:0]  addr;
        logic [IMG_W-1:0]   img;
        logic [LIMIT_W-1:0] gdt_lim;
        logic [BASE_W-1:0]  gdt_base;
        logic [LIMIT_W-1:0] idt_lim;
        logic [BASE_W-1:0]  idt_base;
        logic [3:0]         cr0;
        logic               done;
        fault_e             fcode;
        logic               unsup;
        logic               mswv;
        logic [15:0]        msw;
    } unit_t;

    unit_t q, d;

    op_e             dec_op;
    fault_e          dec_fault;
    logic            dec_unsup, dec_mem, dec_rd_reg, dec_wr_reg;
    logic [NB_W-1:0] dec_nbytes;
    logic            x_go, x_active, x_last, x_failed;
    logic [NB_W-1:0] x_idx;
    logic [15:0]     msw_now;
    logic            accept;
    logic            unused_hi;

    assign dec_op    = op_e'(op_sel);
    assign msw_now   = {12'b0, q.cr0};
    assign accept    = start && !x_active;
    assign unused_hi = ^rm_word[15:4];

    dtr_decode #(.IMG_BYTES(IMG_BYTES), .MSW_BYTES(MSW_BYTES)) u_decode (
        .op(dec_op), .is_mem(op_is_mem), .cpl(cpl), .lock_pfx(lock_pfx),
        .pe_now(q.cr0[0]), .opnd_pe(rm_word[0]),
        .fault(dec_fault), .unsup(dec_unsup), .need_mem(dec_mem),
        .nbytes(dec_nbytes), .msw_rd_reg(dec_rd_reg), .msw_wr_reg(dec_wr_reg)
    );

    assign x_go = accept && (dec_fault == FC_NONE) && !dec_unsup && dec_mem;

    dtr_xfer #(.MAX_BYTES(IMG_BYTES)) u_xfer (
        .clk(clk), .rst_n(rst_n), .go(x_go), .count(dec_nbytes),
        .ack(mem_ack), .fault(mem_fault),
        .active(x_active), .idx(x_idx), .last_ok(x_last), .failed(x_failed)
    );

    always_comb begin
        d       = q;
        d.done  = 1'b0;
        d.fcode = FC_NONE;
        d.unsup = 1'b0;
        d.mswv  = 1'b0;
        if (accept) begin
            d.op   = dec_op;
            d.seg  = seg_ovr_en ? seg_ovr : SEG_DATA;
            d.addr = eff_addr;
            unique case (dec_op)
                OP_STORE_GDT: d.img = {q.gdt_base, q.gdt_lim};
                OP_STORE_IDT: d.img = {q.idt_base, q.idt_lim};
                OP_READ_MSW:  d.img = IMG_W'(msw_now);
                default:      d.img = '0;
            endcase
            if (dec_fault != FC_NONE || dec_unsup) begin
                d.done  = 1'b1;
                d.fcode = dec_fault;
                d.unsup = dec_unsup;
            end else if (dec_rd_reg) begin
                d.done = 1'b1;
                d.mswv = 1'b1;
                d.msw  = msw_now;
            end else if (dec_wr_reg) begin
                d.done = 1'b1;
                d.cr0  = rm_word[3:0];
            end
        end
        if (x_active && mem_ack && !mem_fault && !op_writes_mem(q.op)) begin
            d.img[int'(x_idx)*8 +: 8] = mem_rdata;
        end
        if (x_failed) begin
            d.done  = 1'b1;
            d.fcode = FC_XFER;
        end
        if (x_last) begin
            d.done = 1'b1;
            unique case (q.op)
                OP_LOAD_GDT: begin
                    d.gdt_lim  = d.img[LIMIT_W-1:0];
                    d.gdt_base = d.img[IMG_W-1:LIMIT_W];
                end
                OP_LOAD_IDT: begin
                    d.idt_lim  = d.img[LIMIT_W-1:0];
                    d.idt_base = d.img[IMG_W-1:LIMIT_W];
                end
                OP_WRITE_MSW: begin
                    if (msw_blocked(q.cr0[0], d.img[0])) d.fcode = FC_GP;
                    else                                 d.cr0   = d.img[3:0];
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q          <= '0;
            q.op       <= OP_STORE_GDT;
            q.gdt_lim  <= '1;
            q.idt_lim  <= '1;
            q.fcode    <= FC_NONE;
        end else begin
            q <= d;
        end
    end

    assign mem_req     = x_active;
    assign mem_we      = op_writes_mem(q.op);
    assign mem_seg     = q.seg;
    assign mem_addr    = q.addr + ADDR_W'(x_idx);
    assign mem_wdata   = q.img[int'(x_idx)*8 +: 8];
    assign done        = q.done;
    assign fault_valid = q.done && (q.fcode != FC_NONE);
    assign fault_code  = q.fcode;
    assign unsupported = q.unsup;
    assign msw_valid   = q.mswv;
    assign msw_out     = q.msw;
    assign gdt_limit   = q.gdt_lim;
    assign gdt_base    = q.gdt_base;
    assign idt_limit   = q.idt_lim;
    assign idt_base    = q.idt_base;
    assign cr0_low     = q.cr0;

    p_pe_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        q.cr0[0] |=> q.cr0[0]);

    p_fault_keeps_cr0_r9: assert property (@(posedge clk) disable iff (!rst_n)
        fault_valid |-> (cr0_low == $past(cr0_low)));

    p_gdt_commit_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(x_last && q.op == OP_LOAD_GDT) |=> ($stable(gdt_limit) && $stable(gdt_base)));

    p_idt_commit_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(x_last && q.op == OP_LOAD_IDT) |=> ($stable(idt_limit) && $stable(idt_base)));

    p_unsup_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        unsupported |-> (done && !fault_valid));

    p_ud_no_req_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_valid && fault_code == FC_UD) |-> !mem_req);

    p_req_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));

endmodule

// File: tb/dtr_unit_bench.sv
module dtr_unit_bench;
    import dtr_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [2:0]  op_sel = '0;
    logic        op_is_mem = 1'b0;
    logic [31:0] eff_addr = '0;
    logic        seg_ovr_en = 1'b0;
    logic [2:0]  seg_ovr = '0;
    logic [1:0]  cpl = '0;
    logic        lock_pfx = 1'b0;
    logic [15:0] rm_word = '0;
    logic        mem_req, mem_we;
    logic [2:0]  mem_seg;
    logic [31:0] mem_addr;
    logic [7:0]  mem_wdata;
    logic        mem_ack = 1'b0;
    logic [7:0]  mem_rdata = '0;
    logic        mem_fault = 1'b0;
    logic        done, fault_valid, unsupported, msw_valid;
    logic [1:0]  fault_code;
    logic [15:0] msw_out, gdt_limit, idt_limit;
    logic [31:0] gdt_base, idt_base;
    logic [3:0]  cr0_low;

    always #5 clk = ~clk;

    dtr_unit u_dtr_unit (
        .clk(clk), .rst_n(rst_n), .start(start), .op_sel(op_sel), .op_is_mem(op_is_mem),
        .eff_addr(eff_addr), .seg_ovr_en(seg_ovr_en), .seg_ovr(seg_ovr), .cpl(cpl),
        .lock_pfx(lock_pfx), .rm_word(rm_word), .mem_req(mem_req), .mem_we(mem_we),
        .mem_seg(mem_seg), .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack),
        .mem_rdata(mem_rdata), .mem_fault(mem_fault), .done(done), .fault_valid(fault_valid),
        .fault_code(fault_code), .unsupported(unsupported), .msw_valid(msw_valid),
        .msw_out(msw_out), .gdt_limit(gdt_limit), .gdt_base(gdt_base),
        .idt_limit(idt_limit), .idt_base(idt_base), .cr0_low(cr0_low)
    );

    // Memory model: read image written by the stimulus, write image written by the model.
    logic [7:0]  rmem [64];
    logic [7:0]  wmem [64];
    logic [31:0] fault_addr = 32'hFFFF_FFFF;
    logic [2:0]  last_seg = '0;
    int          done_cnt = 0;
    int          req_cnt = 0;

    always @(negedge clk) begin
        if (done) done_cnt++;
        if (mem_req) begin
            req_cnt++;
            last_seg = mem_seg;
            mem_ack  = 1'b1;
            mem_fault = (mem_addr == fault_addr);
            if (mem_we) wmem[mem_addr[5:0]] = mem_wdata;
            else        mem_rdata = rmem[mem_addr[5:0]];
        end else begin
            mem_ack   = 1'b0;
            mem_fault = 1'b0;
        end
    end

    int n_checks = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    logic [1:0]  r_code;
    logic        r_unsup, r_mv, r_fv;
    logic [15:0] r_mo;

    // Called at a negedge with the unit idle; returns at the negedge where done is seen.
    task automatic run(input logic [2:0] op, input logic mem, input logic [1:0] pl,
                       input logic lk, input logic [15:0] w, input logic [31:0] a,
                       input logic ovr, input logic [2:0] sg, input logic stray);
        int waited = 0;
        op_sel = op; op_is_mem = mem; cpl = pl; lock_pfx = lk; rm_word = w;
        eff_addr = a; seg_ovr_en = ovr; seg_ovr = sg; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (stray) begin
            op_sel = 3'd6; op_is_mem = 1'b0; cpl = 2'd0; lock_pfx = 1'b0;
            rm_word = 16'h0001; start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        while (!done && waited < 50) begin
            @(negedge clk);
            waited++;
        end
        r_code = fault_code; r_unsup = unsupported; r_mv = msw_valid;
        r_mo = msw_out; r_fv = fault_valid;
    endtask

    typedef struct packed {
        logic [2:0]  op;
        logic        mem;
        logic [1:0]  pl;
        logic        lk;
        logic [15:0] w;
        logic [1:0]  code;
        logic        unsup;
        logic [3:0]  cr0;
        logic        rwv;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VECS [NV] = '{
        '{3'd0, 1'b0, 2'd0, 1'b0, 16'h0000, 2'd1, 1'b0, 4'h0, 1'b0}, // R5 store gdt reg form
        '{3'd1, 1'b0, 2'd3, 1'b0, 16'h0000, 2'd1, 1'b0, 4'h0, 1'b0}, // R5 store idt reg form
        '{3'd2, 1'b0, 2'd0, 1'b0, 16'h0000, 2'd1, 1'b0, 4'h0, 1'b0}, // R5 load gdt reg form
        '{3'd3, 1'b0, 2'd3, 1'b0, 16'h0000, 2'd2, 1'b0, 4'h0, 1'b0}, // R6 priv before form
        '{3'd5, 1'b1, 2'd0, 1'b0, 16'h0000, 2'd1, 1'b0, 4'h0, 1'b0}, // R11 reserved
        '{3'd7, 1'b1, 2'd0, 1'b0, 16'h0000, 2'd0, 1'b1, 4'h0, 1'b0}, // R11 unsupported
        '{3'd4, 1'b0, 2'd0, 1'b1, 16'h0000, 2'd1, 1'b0, 4'h0, 1'b0}, // R10 lock
        '{3'd6, 1'b0, 2'd1, 1'b0, 16'h0009, 2'd2, 1'b0, 4'h0, 1'b0}, // R6 msw load cpl 1
        '{3'd6, 1'b0, 2'd0, 1'b0, 16'h0009, 2'd0, 1'b0, 4'h9, 1'b0}, // R8 set PE
        '{3'd6, 1'b0, 2'd0, 1'b0, 16'h0002, 2'd2, 1'b0, 4'h9, 1'b0}, // R9 clear PE refused
        '{3'd6, 1'b0, 2'd0, 1'b0, 16'hFFF5, 2'd0, 1'b0, 4'h5, 1'b0}, // R8 only nibble taken
        '{3'd4, 1'b0, 2'd3, 1'b0, 16'h0000, 2'd0, 1'b0, 4'h5, 1'b1}  // R7 msw read reg form
    };

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        int snap;
        for (int i = 0; i < 64; i++) begin
            rmem[i] = 8'h00;
            wmem[i] = 8'h00;
        end
        rmem[6'h20] = 8'h34; rmem[6'h21] = 8'h12; rmem[6'h22] = 8'h78;
        rmem[6'h23] = 8'h56; rmem[6'h24] = 8'h34; rmem[6'h25] = 8'h12;
        rmem[6'h28] = 8'hAA; rmem[6'h29] = 8'h55; rmem[6'h2A] = 8'hEF;
        rmem[6'h2B] = 8'hBE; rmem[6'h2C] = 8'hAD; rmem[6'h2D] = 8'hDE;
        rmem[6'h3A] = 8'h0B; rmem[6'h3B] = 8'h00;
        rmem[6'h3C] = 8'h0A; rmem[6'h3D] = 8'h00;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1 gdt_limit", gdt_limit, 16'hFFFF);
        check("R1 gdt_base", gdt_base, 32'h0);
        check("R1 idt_limit", idt_limit, 16'hFFFF);
        check("R1 idt_base", idt_base, 32'h0);
        check("R1 cr0_low", cr0_low, 4'h0);
        check("R1 idle outputs", {done, fault_valid, mem_req}, 3'b000);

        // Vector walk: immediate outcomes, no memory traffic (R5, R10)
        snap = req_cnt;
        for (int i = 0; i < NV; i++) begin
            run(VECS[i].op, VECS[i].mem, VECS[i].pl, VECS[i].lk, VECS[i].w,
                32'h0, 1'b0, 3'd0, 1'b0);
            check($sformatf("vector %0d fault_code", i), r_code, VECS[i].code);
            check($sformatf("vector %0d fault_valid", i), r_fv, VECS[i].code != 2'd0);
            check($sformatf("vector %0d unsupported", i), r_unsup, VECS[i].unsup);
            check($sformatf("vector %0d cr0_low", i), cr0_low, VECS[i].cr0);
            check($sformatf("vector %0d msw_valid", i), r_mv, VECS[i].rwv);
            if (VECS[i].rwv) check($sformatf("R7 vector %0d msw_out", i), r_mo, {12'h0, VECS[i].cr0});
            @(negedge clk);
        end
        check("R5 R10 no requests during vector walk", req_cnt, snap);
        check("R11 tables untouched", {gdt_limit, idt_limit}, 32'hFFFF_FFFF);

        // R2 store reset gdt, default segment R12
        run(3'd0, 1'b1, 2'd3, 1'b0, 16'h0, 32'h10, 1'b0, 3'd0, 1'b0);
        check("R2 store gdt code", r_code, 2'd0);
        check("R2 store gdt image", {wmem[6'h15], wmem[6'h14], wmem[6'h13], wmem[6'h12], wmem[6'h11], wmem[6'h10]},
              48'h0000_0000_FFFF);
        check("R12 default segment", last_seg, 3'd3);
        @(negedge clk);

        // R3 load gdt with override segment R12
        run(3'd2, 1'b1, 2'd0, 1'b0, 16'h0, 32'h20, 1'b1, 3'd5, 1'b0);
        check("R3 load gdt code", r_code, 2'd0);
        check("R3 gdt_limit", gdt_limit, 16'h1234);
        check("R3 gdt_base", gdt_base, 32'h1234_5678);
        check("R12 override segment", last_seg, 3'd5);
        @(negedge clk);

        // R3 load idt, then R2 store it back
        run(3'd3, 1'b1, 2'd0, 1'b0, 16'h0, 32'h28, 1'b0, 3'd0, 1'b0);
        check("R3 idt_limit", idt_limit, 16'h55AA);
        check("R3 idt_base", idt_base, 32'hDEAD_BEEF);
        @(negedge clk);
        run(3'd1, 1'b1, 2'd0, 1'b0, 16'h0, 32'h30, 1'b0, 3'd0, 1'b0);
        check("R2 store idt image", {wmem[6'h35], wmem[6'h34], wmem[6'h33], wmem[6'h32], wmem[6'h31], wmem[6'h30]},
              48'hDEAD_BEEF_55AA);
        @(negedge clk);

        // R4 fault in the middle of a gdt load
        fault_addr = 32'h2B;
        run(3'd2, 1'b1, 2'd0, 1'b0, 16'h0, 32'h28, 1'b0, 3'd0, 1'b0);
        fault_addr = 32'hFFFF_FFFF;
        check("R4 fault code", r_code, 2'd3);
        check("R4 gdt kept", {gdt_limit, gdt_base}, 48'h1234_1234_5678);
        @(negedge clk);

        // R7 status word to memory
        run(3'd4, 1'b1, 2'd2, 1'b0, 16'h0, 32'h38, 1'b0, 3'd0, 1'b0);
        check("R7 msw memory image", {wmem[6'h39], wmem[6'h38]}, 16'h0005);
        check("R7 msw memory not reg result", r_mv, 1'b0);
        @(negedge clk);

        // R8 status word from memory
        run(3'd6, 1'b1, 2'd0, 1'b0, 16'h0, 32'h3A, 1'b0, 3'd0, 1'b0);
        check("R8 msw load memory code", r_code, 2'd0);
        check("R8 cr0 from memory", cr0_low, 4'hB);
        @(negedge clk);

        // R9 memory operand trying to clear PE
        run(3'd6, 1'b1, 2'd0, 1'b0, 16'h0, 32'h3C, 1'b0, 3'd0, 1'b0);
        check("R9 clear PE memory code", r_code, 2'd2);
        check("R9 cr0 kept", cr0_low, 4'hB);
        @(negedge clk);

        // R13 stray start during an idt load
        snap = done_cnt;
        run(3'd3, 1'b1, 2'd0, 1'b0, 16'h0, 32'h20, 1'b0, 3'd0, 1'b1);
        @(negedge clk);
        @(negedge clk);
        check("R13 single done", done_cnt - snap, 1);
        check("R13 cr0 unchanged by stray", cr0_low, 4'hB);
        check("R13 idt loaded", {idt_limit, idt_base}, 48'h1234_1234_5678);

        // R10 lock on a memory-form store
        snap = req_cnt;
        run(3'd0, 1'b1, 2'd0, 1'b1, 16'h0, 32'h10, 1'b0, 3'd0, 1'b0);
        check("R10 lock code", r_code, 2'd1);
        @(negedge clk);
        check("R10 lock no request", req_cnt, snap);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

endmodule